// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA data). It gives a bus master byte-wide read and write access to a bank of 17 registers, indexed 00h to 10h, through a pointer that advances by one after each data byte. The block answers only to one fixed 7-bit device address. It samples SCL and SDA with the system clock. It pulls SDA low through an output-enable, and the pad is open-drain.

Register contents live outside the block and arrive on a flat input vector. The first seven registers (00h-06h) are the running time counters. The block keeps a private copy of those seven bytes, and every read of them is served from that copy. The copy is refreshed on each START, on each STOP, and when the pointer wraps from 10h to 00h. A multibyte read therefore sees one consistent instant of a clock that keeps running. Registers 07h-10h are read straight from the input vector.

Writes leave the block as a one-cycle strobe that carries the address and data. The strobe has no ready signal, and the register bank must accept a strobe on the cycle it appears. Strobes are spaced at least one bus byte apart, so a register bank that accepts every strobe never needs to push back. The pointer and the time copy stay in place across a repeated START.

Top module: `twsl_regif`

## Requirements
- R1: A byte is only received after a START, which is SDA falling while SCL is high. Bits clocked on an idle bus, or after a STOP (SDA rising while SCL is high), get no acknowledge and cause no write.
- R2: The address byte is sent MSB first. Its upper seven bits must be 1101000, and bit 0 is the direction (0 = write, so D0h; 1 = read, so D1h). A matching byte is acknowledged by pulling SDA low during the ninth clock. Any other byte is not acknowledged, and the slave leaves SDA released for all bytes up to the next START.
- R3: In a write transfer, the first byte after the address is acknowledged and loads the pointer, and no write strobe is issued for it. A pointer byte above 10h loads 00h.
- R4: Each later byte of a write transfer is acknowledged and produces exactly one single-cycle write strobe. The strobe carries the pointer value and the received byte, and is issued during that byte's acknowledge clock. The pointer then advances by one.
- R5: A read transfer starts at the pointer value left by the previous transfer. Bytes are sent MSB first, and the pointer advances by one after each byte.
- R6: A master NACK (SDA high in the ninth clock of a read byte) ends the read. SDA stays released until the next START.
- R7: The pointer advances from 10h to 00h, in both reads and writes.
- R8: Reads of 00h-06h return the live values as they were at the most recent START, STOP or wrap. Later changes to the live inputs are not seen until the next of those events.
- R9: When the pointer wraps to 00h, the time copy is refreshed at that moment, so bytes read after the wrap reflect the live values at the wrap.
- R10: A repeated START in the middle of a byte discards that byte without a write and restarts address reception. The pointer keeps its value.
- R11: After reset, SDA is released, no write strobe is active and the pointer is 00h.
- R12: Reads of 07h-10h return the live input value at the time the byte is loaded for sending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen at the pad, asynchronous |
| sda_oe | output | 1 | High pulls SDA low; low releases it |
| wr_valid | output | 1 | One-cycle write strobe |
| wr_addr | output | 5 | Register index of the write |
| wr_data | output | 8 | Byte to be written |
| live_regs | input | 136 | Current register contents, byte i at bits 8i+7..8i |

## Verification
A pointer that is off by one shows on SDA in the very next byte read, because a neighbouring register's value comes out. In a write, it shows as a strobe address that differs from the expected one in the cycle of the acknowledge. A stale or early time copy returns old bytes in the read that follows. The test moves the live time inputs just after START and just before a wrap, so the copy's timing is pinned to within one bus byte. A state machine that is out of step shows within one bit time, as a missing acknowledge or SDA held low where the master expects it released.

// File: rtl/twsl_pkg.sv
package twsl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } twsl_state_e;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_PTR,
    PH_DATA
  } twsl_phase_e;
endpackage

// File: rtl/twsl_sync.sv
module twsl_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // [0],[1] synchronizer, [2] previous synchronized sample
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_s     = scl_q[1];
  assign sda_s     = sda_q[1];
  assign scl_rise  = scl_q[1] & ~scl_q[2];
  assign scl_fall  = ~scl_q[1] & scl_q[2];
  assign start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/twsl_snap.sv
module twsl_snap #(
  parameter int NREG  = 17,
  parameter int NTIME = 7,
  localparam int AW   = $clog2(NREG),
  localparam int LW   = NREG * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] live_regs,
  input  logic          snap_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] live_b [NREG];
  logic [7:0] view   [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_byte
    assign live_b[i] = live_regs[i*8 +: 8];
    if (i < NTIME) begin : g_held
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       view[i] <= '0;
        else if (snap_en) view[i] <= live_b[i];
      end
      // time byte copy follows the live value of the capture cycle
      p_snap_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        snap_en |=> view[i] == $past(live_b[i]));
    end else begin : g_direct
      assign view[i] = live_b[i];
    end
  end

  assign rd_data = view[rd_addr];
endmodule

// File: rtl/twsl_regif.sv
module twsl_regif #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int NREG  = 17,
  parameter int NTIME = 7,
  localparam int AW   = $clog2(NREG),
  localparam int LW   = NREG * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  input  logic [LW-1:0] live_regs
);
  import twsl_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(NREG - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  twsl_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twsl_state_e state;
  twsl_phase_e phase;
  logic          rw;
  logic [3:0]    cnt;
  logic [7:0]    shreg;
  logic [AW-1:0] ptr, ptr_next;
  logic          ptr_inc, wrap, snap_en;
  logic [7:0]    rd_data;

  assign ptr_next = (ptr == LAST) ? '0 : ptr + 1'b1;
  assign ptr_inc  = scl_fall && (
                      (state == ST_RX && cnt == 4'd8 && phase == PH_DATA) ||
                      (state == ST_TX && cnt == 4'd7));
  assign wrap     = ptr_inc && (ptr == LAST);
  assign snap_en  = start_det | stop_det | wrap;

  twsl_snap #(.NREG(NREG), .NTIME(NTIME)) u_snap (
    .clk(clk), .rst_n(rst_n), .live_regs(live_regs), .snap_en(snap_en),
    .rd_addr(ptr), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= PH_DEV;
      rw       <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      ptr      <= '0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (start_det) begin
        state  <= ST_RX;
        phase  <= PH_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && cnt < 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              case (phase)
                PH_DEV: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    rw     <= shreg[0];
                    sda_oe <= 1'b1;
                    state  <= ST_ACK;
                  end else begin
                    state  <= ST_IGNORE;
                  end
                end
                PH_PTR: begin
                  ptr    <= (shreg < NREG) ? shreg[AW-1:0] : '0;
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                end
                default: begin
                  wr_valid <= 1'b1;
                  wr_addr  <= ptr;
                  wr_data  <= shreg;
                  sda_oe   <= 1'b1;
                  state    <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (phase == PH_DEV && rw) begin
                state  <= ST_TX;
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
              end else begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
                phase  <= (phase == PH_DEV) ? PH_PTR : PH_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                state  <= ST_MACK;
                sda_oe <= 1'b0;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise && sda_s) begin
              state <= ST_IGNORE;
            end else if (scl_fall) begin
              state  <= ST_TX;
              cnt    <= '0;
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
            end
          end
          default: ;
        endcase
      end
      if (ptr_inc) ptr <= ptr_next;
    end
  end

  // write strobe lasts one cycle
  p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // strobes only come out of data bytes
  p_wr_data_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> phase == PH_DATA);
  // pointer never leaves the register range
  p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);
  // advancing from the last index lands on zero
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && ptr == LAST) |=> ptr == '0);
  // an ignored bus is never driven
  p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IGNORE |-> !sda_oe);
  // the slave only starts pulling SDA while SCL is low
  p_oe_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
endmodule

// File: tb/tb_twsl_regif.sv
module tb_twsl_regif;
  localparam int NREG = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, wr_valid;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] live [NREG];
  logic [NREG*8-1:0] live_flat;
  wire  sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < NREG; i++) live_flat[i*8 +: 8] = live[i];

  twsl_regif dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .live_regs(live_flat)
  );

  int vec = 0, err = 0;
  int mon_vec = 0, mon_err = 0;
  int wr_idx = 0;
  logic [12:0] exp_wr [$];
  bit done = 0;

  // per-clock comparison of write strobes against the expected stream
  always @(negedge clk) begin
    if (rst_n) begin
      mon_vec++;
      if (wr_valid) begin
        if (wr_idx >= exp_wr.size()) begin
          mon_err++;
          $display("FAIL R4 unexpected write act=%0h:%0h exp=none", wr_addr, wr_data);
        end else begin
          if ({wr_addr, wr_data} !== exp_wr[wr_idx]) begin
            mon_err++;
            $display("FAIL R4 write act=%0h:%0h exp=%0h:%0h", wr_addr, wr_data,
                     exp_wr[wr_idx][12:8], exp_wr[wr_idx][7:0]);
          end
          wr_idx++;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vec++;
    if (act !== exp) begin
      err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (10) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp();
    scl_m = 1'b1; hp();
    sda_m = 1'b0; hp();
    scl_m = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp();
    scl_m = 1'b1; hp();
    sda_m = 1'b1; hp(); hp();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hp();
      scl_m = 1'b1; hp();
      scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; hp();
    scl_m = 1'b1;
    repeat (5) @(negedge clk);
    ack = sda_line;
    repeat (5) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hp();
      scl_m = 1'b1;
      repeat (5) @(negedge clk);
      b = {b[6:0], sda_line};
      repeat (5) @(negedge clk);
      scl_m = 1'b0;
    end
    sda_m = nack; hp();
    scl_m = 1'b1; hp();
    scl_m = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    bus_start();
    send_byte(8'hD0, a); chk("R2 addr ack", a, 0);
    send_byte(p, a);     chk("R3 ptr ack", a, 0);
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    for (int i = 0; i < NREG; i++) live[i] = 8'h40 + 8'(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 sda_oe after reset", sda_oe, 0);
    chk("R11 wr_valid after reset", wr_valid, 0);

    // R11 pointer starts at 00h, R5 read from it
    bus_start();
    send_byte(8'hD1, a); chk("R2 read addr ack", a, 0);
    recv_byte(1, b);     chk("R11 first read at 00h", b, 8'h40);
    bus_stop();

    // R3 pointer load, R4 data writes
    exp_wr.push_back({5'h08, 8'h11});
    exp_wr.push_back({5'h09, 8'h22});
    exp_wr.push_back({5'h0A, 8'h33});
    bus_start();
    send_byte(8'hD0, a); chk("R2 write addr ack", a, 0);
    send_byte(8'h08, a); chk("R3 ptr ack", a, 0);
    send_byte(8'h11, a); chk("R4 data ack", a, 0);
    send_byte(8'h22, a); chk("R4 data ack", a, 0);
    send_byte(8'h33, a); chk("R4 data ack", a, 0);
    bus_stop();
    chk("R4 write count", wr_idx, 3);

    // R5 read continues at stored pointer 0Bh, R12 direct registers
    bus_start();
    send_byte(8'hD1, a); chk("R5 addr ack", a, 0);
    recv_byte(0, b);     chk("R12 read 0Bh", b, 8'h4B);
    recv_byte(1, b);     chk("R5 read 0Ch", b, 8'h4C);
    bus_stop();

    // R7 write wrap 10h -> 00h
    exp_wr.push_back({5'h0F, 8'hA1});
    exp_wr.push_back({5'h10, 8'hA2});
    exp_wr.push_back({5'h00, 8'hA3});
    bus_start();
    send_byte(8'hD0, a);
    send_byte(8'h0F, a);
    send_byte(8'hA1, a);
    send_byte(8'hA2, a); chk("R7 ack at 10h", a, 0);
    send_byte(8'hA3, a); chk("R7 ack after wrap", a, 0);
    bus_stop();
    chk("R7 write count", wr_idx, 6);

    // R2 foreign address ignored until next START
    bus_start();
    send_byte(8'hA0, a); chk("R2 foreign addr nack", a, 1);
    send_byte(8'h55, a); chk("R2 ignored byte nack", a, 1);
    bus_stop();
    chk("R2 no write", wr_idx, 6);

    // R1 byte without START
    scl_m = 1'b0; hp();
    send_byte(8'hD0, a); chk("R1 no START nack", a, 1);
    send_byte(8'h01, a); chk("R1 no START nack 2", a, 1);
    bus_stop();
    chk("R1 no write", wr_idx, 6);

    // R8 snapshot at START
    set_ptr(8'h00);
    for (int i = 0; i < 7; i++) live[i] = 8'h10 + 8'(i);
    bus_start();
    send_byte(8'hD1, a);
    for (int i = 0; i < 7; i++) live[i] = 8'h90 + 8'(i);
    for (int i = 0; i < 7; i++) begin
      recv_byte(i == 6, b);
      chk("R8 coherent time byte", b, 8'h10 + i);
    end
    bus_stop();

    // R9 snapshot at wrap
    set_ptr(8'h0F);
    bus_start();
    send_byte(8'hD1, a);
    live[0] = 8'h5A;
    recv_byte(0, b); chk("R12 read 0Fh", b, 8'h4F);
    recv_byte(0, b); chk("R7 read 10h", b, 8'h50);
    recv_byte(0, b); chk("R9 read 00h after wrap", b, 8'h5A);
    recv_byte(1, b); chk("R9 read 01h after wrap", b, 8'h91);
    bus_stop();

    // R10 repeated START mid-byte keeps pointer, drops byte
    bus_start();
    send_byte(8'hD0, a);
    send_byte(8'h03, a);
    send_bits(8'hF0, 4);
    bus_start();
    send_byte(8'hD1, a); chk("R10 addr ack after restart", a, 0);
    recv_byte(1, b);     chk("R10 read at kept ptr", b, 8'h93);
    bus_stop();
    chk("R10 no write", wr_idx, 6);

    // R6 NACK ends read
    bus_start();
    send_byte(8'hD1, a);
    recv_byte(1, b); chk("R6 read 04h", b, 8'h94);
    recv_byte(1, b); chk("R6 released after NACK", b, 8'hFF);
    bus_stop();
    chk("R6 sda_oe idle", sda_oe, 0);
    chk("R4 all writes seen", wr_idx, exp_wr.size());

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec + mon_vec, err + mon_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      err++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec + mon_vec, err + mon_err);
      $finish;
    end
  end
endmodule